// File: doc/BRIEF.md
# Multi-Domain Clock Stop Controller

This block sits between a set of free-running clock sources and the clock pins they feed. It turns a CPU-rate clock, a PCI-rate clock, a group of auxiliary clocks and a reference clock into gated outputs. A low-active sleep request stops almost every output. A separate low-active PCI hold request stops only the stoppable PCI outputs. Every stop and every restart happens while the affected clock is in the phase where it parks, so the outputs never glitch.

The sleep request counts only after it has been sampled low on two consecutive CPU rising edges. While asleep, the true CPU output is either kept high and driven, or both CPU outputs are released, depending on a static float option. Every other output parks low. On wake-up the true CPU output is driven high at once. Toggling then resumes only after a parameterised lock-delay count of CPU cycles, so the downstream PLL can settle. Each clock domain takes the run decision through its own synchronizer. The reference domain uses a longer chain because it may need more than one of its own cycles to come to rest.

Top module: `clkstop_ctrl`

## Requirements
- R1: The sleep request takes effect only after it is sampled low on two consecutive rising edges of the CPU clock. The complement output-enable falls right after the second of those edges. A request that is low at only one rising edge has no effect.
- R2: While asleep, the PCI, PCI-side, auxiliary and reference outputs stop with no rising edge and rest low. The true CPU output makes no rising edge.
- R3: With the float option at 0, sleep keeps the true CPU output at 1 and its enable at 1. The complement enable is 0.
- R4: With the float option at 1, sleep drives both CPU output-enables to 0.
- R5: At the first CPU rising edge that samples the sleep request high again, the true CPU enable goes to 1 and the true CPU output stays at 1. This holds for either float setting. The complement enable stays 0.
- R6: The complement enable returns to 1, and CPU toggling resumes, exactly LOCK_CYCLES CPU rising edges after the edge named in R5. The same count applies after reset is released.
- R7: While the PCI hold request is low, every PCI output and every PCI-side output whose bit in SIDE_STOP_MASK is 1 stops low. Side outputs whose mask bit is 0, the auxiliary outputs, the reference output and the CPU pair keep toggling. Raising the request restarts the held outputs.
- R8: The PCI hold request and the sleep request act independently. Waking from sleep while the hold request is low restarts every output except the held PCI outputs.
- R9: No gated output ever makes a runt pulse. For the low-parking outputs, every high pulse lasts exactly half a source period and every low pulse lasts at least that long. For the true CPU output, every low pulse lasts exactly half a CPU period.
- R10: During reset, the low-parking outputs are 0, the true CPU output and its enable are 1, and the complement enable is 0.
- R11: Once running, each output makes the same number of rising edges as its source clock over the same interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | Free-running CPU-rate clock |
| pci_clk_i | input | 1 | Free-running PCI-rate clock |
| aux_clk_i | input | N_AUX | Free-running auxiliary group clocks |
| ref_clk_i | input | 1 | Free-running reference clock |
| sleep_n_i | input | 1 | Active-low sleep request, sampled on the CPU clock |
| pci_hold_n_i | input | 1 | Active-low PCI stop request, sampled on the PCI clock |
| cpu_float_i | input | 1 | 1: release both CPU outputs in sleep; 0: hold true output high |
| cpu_true_o | output | 1 | Gated true CPU clock, parks high |
| cpu_comp_o | output | 1 | Gated complement CPU clock |
| cpu_true_oe_o | output | 1 | Drive enable for the true CPU output |
| cpu_comp_oe_o | output | 1 | Drive enable for the complement CPU output |
| pci_main_o | output | N_PCI | Stoppable PCI clocks |
| pci_side_o | output | N_SIDE | PCI-side clocks, stoppable where SIDE_STOP_MASK is 1 |
| aux_o | output | N_AUX | Gated auxiliary clocks |
| ref_o | output | 1 | Gated reference clock |

## Verification
The two functions that can meet in one cycle are waking from sleep and asserting the PCI hold request. The bench lowers the hold request at the same instant it raises the sleep request. It then checks three things: the prompt true-output drive, the exact lock-delay edge, and edge counts showing that everything restarts except the held PCI outputs, which must stay low until the hold is released. A runt monitor runs across all of these transitions and measures every pulse width against half the source period.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

   // Level at which a gated clock rests while stopped
   typedef enum logic {
      PARK_LOW  = 1'b0,
      PARK_HIGH = 1'b1
   } park_e;

   // Width of a counter that must reach the value n
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("clkstop_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) chain_q <= {STAGES{RST_VAL}};
      else          chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate
   import clkstop_pkg::*;
#(
   parameter park_e PARK = PARK_LOW
) (
   input  logic clk_i,
   input  logic en_i,
   output logic gclk_o
);

   logic en_l;

   if (PARK == PARK_LOW) begin : g_park_low
      // enable may only move while the clock is low
      always_latch begin
         if (!clk_i) en_l <= en_i;
      end
      assign gclk_o = clk_i & en_l;
   end else begin : g_park_high
      // enable may only move while the clock is high
      always_latch begin
         if (clk_i) en_l <= en_i;
      end
      assign gclk_o = clk_i | ~en_l;
   end

endmodule

// File: rtl/clkstop_pdctl.sv
`timescale 1ns/1ps
module clkstop_pdctl
   import clkstop_pkg::*;
#(
   parameter int LOCK_CYCLES = 64
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic sleep_n_i,
   output logic sleep_act_o,
   output logic run_o
);

   localparam int             CW       = cnt_width(LOCK_CYCLES);
   localparam logic [CW-1:0]  LOCK_MAX = CW'(LOCK_CYCLES);

   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("clkstop_pdctl: LOCK_CYCLES must be at least 1");
   end

   logic          samp_q;
   logic          act_q;
   logic [CW-1:0] lock_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         samp_q <= 1'b1;
         act_q  <= 1'b0;
         lock_q <= '0;
      end else begin
         samp_q <= sleep_n_i;
         act_q  <= !sleep_n_i && !samp_q;
         if (act_q)                 lock_q <= '0;
         else if (lock_q != LOCK_MAX) lock_q <= lock_q + 1'b1;
      end
   end

   assign sleep_act_o = act_q;
   assign run_o       = !act_q && (lock_q == LOCK_MAX);

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
   import clkstop_pkg::*;
#(
   parameter int              N_PCI           = 7,
   parameter int              N_SIDE          = 3,
   parameter logic [N_SIDE-1:0] SIDE_STOP_MASK = 3'b101,
   parameter int              N_AUX           = 2,
   parameter int              SYNC_STAGES     = 2,
   parameter int              REF_SYNC_STAGES = 3,
   parameter int              LOCK_CYCLES     = 64
) (
   input  logic              rst_n_i,
   input  logic              cpu_clk_i,
   input  logic              pci_clk_i,
   input  logic [N_AUX-1:0]  aux_clk_i,
   input  logic              ref_clk_i,
   input  logic              sleep_n_i,
   input  logic              pci_hold_n_i,
   input  logic              cpu_float_i,
   output logic              cpu_true_o,
   output logic              cpu_comp_o,
   output logic              cpu_true_oe_o,
   output logic              cpu_comp_oe_o,
   output logic [N_PCI-1:0]  pci_main_o,
   output logic [N_SIDE-1:0] pci_side_o,
   output logic [N_AUX-1:0]  aux_o,
   output logic              ref_o
);

   if (N_PCI < 1 || N_SIDE < 1 || N_AUX < 1) begin : g_bad_count
      $error("clkstop_ctrl: every output group needs at least one clock");
   end
   if (REF_SYNC_STAGES <= SYNC_STAGES) begin : g_bad_ref
      $error("clkstop_ctrl: reference chain must be longer than SYNC_STAGES");
   end

   // ---------------- CPU domain: qualification, lock delay, pair -------
   logic sleep_act;
   logic run_cpu;
   logic cpu_gclk;

   clkstop_pdctl #(.LOCK_CYCLES(LOCK_CYCLES)) u_pdctl (
      .clk_i       (cpu_clk_i),
      .rst_n_i     (rst_n_i),
      .sleep_n_i   (sleep_n_i),
      .sleep_act_o (sleep_act),
      .run_o       (run_cpu)
   );

   clkstop_gate #(.PARK(PARK_HIGH)) u_cpu_gate (
      .clk_i  (cpu_clk_i),
      .en_i   (run_cpu),
      .gclk_o (cpu_gclk)
   );

   assign cpu_true_o    = cpu_gclk;
   assign cpu_comp_o    = ~cpu_gclk;
   assign cpu_true_oe_o = run_cpu | ~sleep_act | ~cpu_float_i;
   assign cpu_comp_oe_o = run_cpu;

   // ---------------- PCI domain ----------------------------------------
   logic run_pci;
   logic hold_ok;
   logic en_held;

   clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pci_run_sync (
      .clk_i (pci_clk_i), .rst_n_i (rst_n_i), .d_i (run_cpu), .q_o (run_pci)
   );
   clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pci_hold_sync (
      .clk_i (pci_clk_i), .rst_n_i (rst_n_i), .d_i (pci_hold_n_i), .q_o (hold_ok)
   );

   assign en_held = run_pci & hold_ok;

   for (genvar i = 0; i < N_PCI; i++) begin : g_pci
      clkstop_gate #(.PARK(PARK_LOW)) u_gate (
         .clk_i (pci_clk_i), .en_i (en_held), .gclk_o (pci_main_o[i])
      );
   end

   for (genvar i = 0; i < N_SIDE; i++) begin : g_side
      if (SIDE_STOP_MASK[i]) begin : g_stoppable
         clkstop_gate #(.PARK(PARK_LOW)) u_gate (
            .clk_i (pci_clk_i), .en_i (en_held), .gclk_o (pci_side_o[i])
         );
      end else begin : g_free
         clkstop_gate #(.PARK(PARK_LOW)) u_gate (
            .clk_i (pci_clk_i), .en_i (run_pci), .gclk_o (pci_side_o[i])
         );
      end
   end

   // ---------------- auxiliary domains ---------------------------------
   for (genvar i = 0; i < N_AUX; i++) begin : g_aux
      logic run_aux;
      clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
         .clk_i (aux_clk_i[i]), .rst_n_i (rst_n_i), .d_i (run_cpu), .q_o (run_aux)
      );
      clkstop_gate #(.PARK(PARK_LOW)) u_gate (
         .clk_i (aux_clk_i[i]), .en_i (run_aux), .gclk_o (aux_o[i])
      );
   end

   // ---------------- reference domain (longer chain) -------------------
   logic run_ref;

   clkstop_sync #(.STAGES(REF_SYNC_STAGES), .RST_VAL(1'b0)) u_ref_sync (
      .clk_i (ref_clk_i), .rst_n_i (rst_n_i), .d_i (run_cpu), .q_o (run_ref)
   );
   clkstop_gate #(.PARK(PARK_LOW)) u_ref_gate (
      .clk_i (ref_clk_i), .en_i (run_ref), .gclk_o (ref_o)
   );

endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/1ps
module clkstop_ctrl_chk #(
   parameter int                N_PCI          = 7,
   parameter int                N_SIDE         = 3,
   parameter logic [N_SIDE-1:0] SIDE_STOP_MASK = 3'b101,
   parameter int                SYNC_STAGES    = 2
) (
   input logic              rst_n_i,
   input logic              cpu_clk_i,
   input logic              pci_clk_i,
   input logic              sleep_n_i,
   input logic              pci_hold_n_i,
   input logic              cpu_float_i,
   input logic              cpu_true_o,
   input logic              cpu_true_oe_o,
   input logic              cpu_comp_oe_o,
   input logic [N_PCI-1:0]  pci_main_o,
   input logic [N_SIDE-1:0] pci_side_o
);

   localparam int HOLD_LIM = SYNC_STAGES + 2;

   // PCI edges seen with the hold request low, saturating
   int hold_cnt;
   always_ff @(posedge pci_clk_i or negedge rst_n_i) begin
      if (!rst_n_i)              hold_cnt <= 0;
      else if (pci_hold_n_i)     hold_cnt <= 0;
      else if (hold_cnt < HOLD_LIM) hold_cnt <= hold_cnt + 1;
   end

   p_qualify_r1: assert property (@(posedge cpu_clk_i) disable iff (!rst_n_i)
      (!sleep_n_i && !$past(sleep_n_i) && $past(rst_n_i)) |=> !cpu_comp_oe_o)
      else $error("p_qualify_r1");

   p_park_high_r3: assert property (@(posedge cpu_clk_i) disable iff (!rst_n_i)
      (!cpu_comp_oe_o && !cpu_float_i) |-> (cpu_true_oe_o && cpu_true_o))
      else $error("p_park_high_r3");

   p_float_pair_r4: assert property (@(posedge cpu_clk_i) disable iff (!rst_n_i)
      !cpu_true_oe_o |-> (cpu_float_i && !cpu_comp_oe_o))
      else $error("p_float_pair_r4");

   p_wake_drive_r5: assert property (@(posedge cpu_clk_i) disable iff (!rst_n_i)
      sleep_n_i |=> cpu_true_oe_o)
      else $error("p_wake_drive_r5");

   p_hold_low_r7: assert property (@(negedge pci_clk_i) disable iff (!rst_n_i)
      (hold_cnt >= HOLD_LIM) |->
         (pci_main_o == '0 && (pci_side_o & SIDE_STOP_MASK) == '0))
      else $error("p_hold_low_r7");

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
   .N_PCI          (N_PCI),
   .N_SIDE         (N_SIDE),
   .SIDE_STOP_MASK (SIDE_STOP_MASK),
   .SYNC_STAGES    (SYNC_STAGES)
) u_chk (
   .rst_n_i       (rst_n_i),
   .cpu_clk_i     (cpu_clk_i),
   .pci_clk_i     (pci_clk_i),
   .sleep_n_i     (sleep_n_i),
   .pci_hold_n_i  (pci_hold_n_i),
   .cpu_float_i   (cpu_float_i),
   .cpu_true_o    (cpu_true_o),
   .cpu_true_oe_o (cpu_true_oe_o),
   .cpu_comp_oe_o (cpu_comp_oe_o),
   .pci_main_o    (pci_main_o),
   .pci_side_o    (pci_side_o)
);

// File: tb/clkstop_ctrl_bench.sv
`timescale 1ns/1ps
module clkstop_ctrl_bench;

   localparam int                N_PCI  = 2;
   localparam int                N_SIDE = 3;
   localparam logic [N_SIDE-1:0] S_MASK = 3'b101;
   localparam int                N_AUX  = 2;
   localparam int                LOCK   = 8;
   localparam int                W      = 1 + N_PCI + N_SIDE + N_AUX + 1;
   localparam int                WIN    = 420;

   logic              rst_n = 1'b0;
   logic              cpu_clk = 1'b0, pci_clk = 1'b0, ref_clk = 1'b0;
   logic [N_AUX-1:0]  aux_clk = '0;
   logic              sleep_n = 1'b1, hold_n = 1'b1, cfg = 1'b0;
   logic              cpu_true, cpu_comp, oe_t, oe_c, ref_o;
   logic [N_PCI-1:0]  pci_main;
   logic [N_SIDE-1:0] pci_side;
   logic [N_AUX-1:0]  aux_o;

   always #10 cpu_clk    = ~cpu_clk;
   always #15 pci_clk    = ~pci_clk;
   always #7  aux_clk[0] = ~aux_clk[0];
   always #21 aux_clk[1] = ~aux_clk[1];
   always #35 ref_clk    = ~ref_clk;

   clkstop_ctrl #(
      .N_PCI (N_PCI), .N_SIDE (N_SIDE), .SIDE_STOP_MASK (S_MASK), .N_AUX (N_AUX),
      .SYNC_STAGES (2), .REF_SYNC_STAGES (3), .LOCK_CYCLES (LOCK)
   ) u_clkstop_ctrl (
      .rst_n_i (rst_n), .cpu_clk_i (cpu_clk), .pci_clk_i (pci_clk),
      .aux_clk_i (aux_clk), .ref_clk_i (ref_clk), .sleep_n_i (sleep_n),
      .pci_hold_n_i (hold_n), .cpu_float_i (cfg), .cpu_true_o (cpu_true),
      .cpu_comp_o (cpu_comp), .cpu_true_oe_o (oe_t), .cpu_comp_oe_o (oe_c),
      .pci_main_o (pci_main), .pci_side_o (pci_side), .aux_o (aux_o), .ref_o (ref_o)
   );

   // index 0: CPU true; then PCI main, PCI side, aux, ref
   logic [W-1:0] mon_v;
   assign mon_v = {ref_o, aux_o, pci_side, pci_main, cpu_true};

   int  checks = 0;
   int  errors = 0;
   int  runts  = 0;
   bit  mon_en = 1'b0;
   bit  done   = 1'b0;
   int  cnt [W];
   bit  seen [W];
   real t_last [W];
   logic [W-1:0] prev_v = '0;

   function automatic int half_of(input int i);
      if (i == 0)               return 10;
      if (i <= N_PCI + N_SIDE)  return 15;
      if (i == W - 1)           return 35;
      return (i - 1 - N_PCI - N_SIDE == 0) ? 7 : 21;
   endfunction

   function automatic bit held(input int i);
      if (i >= 1 && i <= N_PCI) return 1'b1;
      if (i > N_PCI && i <= N_PCI + N_SIDE) return S_MASK[i - 1 - N_PCI];
      return 1'b0;
   endfunction

   // edge counter and pulse-width monitor, polled between edges
   initial begin
      for (int i = 0; i < W; i++) begin
         cnt[i] = 0; seen[i] = 1'b0; t_last[i] = 0.0;
      end
   end

   always #0.5 begin
      for (int i = 0; i < W; i++) begin
         if (mon_v[i] !== prev_v[i]) begin
            real wdt;
            real h;
            wdt = $realtime - t_last[i];
            h   = real'(half_of(i));
            if (mon_en && seen[i]) begin
               if (mon_v[i]) begin
                  if ((i == 0) ? (wdt != h) : (wdt < h)) runts++;
               end else begin
                  if ((i == 0) ? (wdt < h) : (wdt != h)) runts++;
               end
            end
            if (mon_v[i]) cnt[i]++;
            seen[i]   = mon_en;
            t_last[i] = $realtime;
            prev_v[i] = mon_v[i];
         end
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge cpu_clk);
      #0.5;
   endtask

   task automatic window(input bit pd, input bit hold, input string req);
      int base [W];
      for (int i = 0; i < W; i++) base[i] = cnt[i];
      #(WIN);
      for (int i = 0; i < W; i++) begin
         int exp;
         exp = (pd || (hold && held(i))) ? 0 : WIN / (2 * half_of(i));
         check(req, $sformatf("rising edges on output %0d", i), cnt[i] - base[i], exp);
         if (exp == 0)
            check(req, $sformatf("park level of output %0d", i), int'(mon_v[i]), (i == 0) ? 1 : 0);
      end
   endtask

   initial begin
      step(6);
      // R10: reset state
      check("R10", "pci main", int'(pci_main), 0);
      check("R10", "pci side", int'(pci_side), 0);
      check("R10", "aux", int'(aux_o), 0);
      check("R10", "ref", int'(ref_o), 0);
      check("R10", "cpu true", int'(cpu_true), 1);
      check("R10", "true enable", int'(oe_t), 1);
      check("R10", "comp enable", int'(oe_c), 0);

      rst_n = 1'b1;
      step(LOCK - 1);
      check("R6", "comp enable one edge before lock after reset", int'(oe_c), 0);
      step(1);
      check("R6", "comp enable at lock after reset", int'(oe_c), 1);
      step(40);
      mon_en = 1'b1;
      window(1'b0, 1'b0, "R11");

      // R7: PCI hold alone
      hold_n = 1'b0;
      step(20);
      window(1'b0, 1'b1, "R7");
      hold_n = 1'b1;
      step(20);
      window(1'b0, 1'b0, "R7");

      // R1: request low at a single edge is ignored
      sleep_n = 1'b0;
      step(1);
      sleep_n = 1'b1;
      check("R1", "comp enable after single low edge", int'(oe_c), 1);
      step(1);
      check("R1", "comp enable after pulse", int'(oe_c), 1);
      window(1'b0, 1'b0, "R1");

      // R1 / R2 / R3: qualified sleep, float option 0
      sleep_n = 1'b0;
      step(1);
      check("R1", "comp enable after first low edge", int'(oe_c), 1);
      step(1);
      check("R1", "comp enable after second low edge", int'(oe_c), 0);
      step(40);
      check("R3", "true enable", int'(oe_t), 1);
      check("R3", "true level", int'(cpu_true), 1);
      check("R3", "comp enable", int'(oe_c), 0);
      window(1'b1, 1'b0, "R2");

      // R5 / R6: wake with float option 0
      sleep_n = 1'b1;
      step(1);
      check("R5", "true enable on wake", int'(oe_t), 1);
      check("R5", "comp enable on wake", int'(oe_c), 0);
      step(LOCK - 1);
      check("R6", "comp enable one edge before lock", int'(oe_c), 0);
      step(1);
      check("R6", "comp enable at lock", int'(oe_c), 1);
      step(40);
      window(1'b0, 1'b0, "R6");

      // R4: sleep with float option 1
      cfg = 1'b1;
      sleep_n = 1'b0;
      step(40);
      check("R4", "true enable", int'(oe_t), 0);
      check("R4", "comp enable", int'(oe_c), 0);
      window(1'b1, 1'b0, "R2");

      // R8: wake and PCI hold in the same cycle
      sleep_n = 1'b1;
      hold_n  = 1'b0;
      step(1);
      check("R5", "true enable on floating wake", int'(oe_t), 1);
      check("R5", "true level on floating wake", int'(cpu_true), 1);
      check("R5", "comp enable on floating wake", int'(oe_c), 0);
      step(LOCK - 1);
      check("R6", "comp enable before lock (hold active)", int'(oe_c), 0);
      step(1);
      check("R6", "comp enable at lock (hold active)", int'(oe_c), 1);
      step(40);
      window(1'b0, 1'b1, "R8");
      hold_n = 1'b1;
      step(20);
      window(1'b0, 1'b0, "R8");

      // R9: no runt pulse anywhere since monitoring began
      check("R9", "runt pulses", runts, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule